// File: doc/BRIEF.md
# Console Device Register Block

This block sits on the memory bus of a 16-bit processor and answers the top page of the address space, 0xFE00 through 0xFFFF, with device registers instead of ordinary memory. It serves three devices: a keyboard input port fed by a character strobe, a display output port that hands a character to the display through a valid/acknowledge handshake, and a machine-control register whose top bit is a run latch driving the processor's clock enable. Each port has a status word in which bit 15 is a ready flag and bit 14 is an interrupt enable. Each port also raises an interrupt request while both of those bits are set.

Two small state machines carry the device state. The keyboard machine has the states KBD_EMPTY and KBD_FULL. The transition CHAR_IN (a strobe) moves it to KBD_FULL and loads the character. The transition CHAR_TAKEN (a bus read of the keyboard data register with no strobe in the same cycle) moves it back to KBD_EMPTY. The display machine has the states DSP_DONE and DSP_BUSY. The transition SEND (a bus write of the display data register while in DSP_DONE) latches the character and enters DSP_BUSY. The transition ACK (the display acknowledging) returns it to DSP_DONE. A strobe that arrives in KBD_FULL overwrites the held character and the machine stays in KBD_FULL. The run latch is a single flip-flop that the bus writes.

The bus port is synchronous. A request is taken at a rising clock edge when `bus_sel` is high. Read data appears on `bus_rdata` in the following cycle. `dev_hit` is combinational and tells the memory system to stay out of the device page.

Top module: `con_io_regs`

## Requirements
- R1: `dev_hit` is 1 exactly when `bus_addr` lies in 0xFE00..0xFFFF, whatever the state of `bus_sel`.
- R2: The keyboard status word at 0xFE00 reads {ready, enable, 14'b0}. A write to it changes only the enable (bit 14); writing bit 15 does not set ready.
- R3: A keyboard strobe sets ready and loads `kbd_char`. Reading 0xFE02 returns the character in bits 7:0 (upper bits 0) and clears ready. If a strobe and such a read fall in the same cycle, the read returns the old character and the new character is left ready.
- R4: The display status word at 0xFE04 reads {done, enable, 14'b0}, and done is 1 after reset.
- R5: Writing 0xFE06 while done is 1 drives `wdata[7:0]` on `dsp_char`, raises `dsp_valid` and clears done from the next cycle on. These stay unchanged until a cycle with `dsp_ack` high, after which `dsp_valid` is 0 and done is 1.
- R6: Writing 0xFE06 while done is 0 has no effect: `dsp_char` keeps the pending character.
- R7: `kbd_irq` is 1 exactly when keyboard ready and enable are both 1; `dsp_irq` is 1 exactly when display done and enable are both 1.
- R8: The control word at 0xFFFE reads {run, 15'b0}. Run is 1 after reset, and a write loads run from `wdata[15]`. The `run` output follows the latch.
- R9: Read data comes one cycle after the request. Undecoded addresses inside the device page, and all addresses outside it, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| dev_hit | output | 1 | Address falls in the device page |
| kbd_strobe | input | 1 | Keyboard has a new character |
| kbd_char | input | 8 | Keyboard character |
| dsp_char | output | 8 | Character presented to the display |
| dsp_valid | output | 1 | Character on dsp_char awaits acknowledge |
| dsp_ack | input | 1 | Display has taken the character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |
| run | output | 1 | Processor clock enable (run latch) |

## Verification
A keyboard machine stuck in KBD_FULL would show up on the first status read after a data read as bit 15 still set, and it would keep `kbd_irq` high once the enable is set. A display machine that leaves DSP_BUSY too early or too late would show on `dsp_valid` and the done bit in the cycle after the acknowledge. A character overwritten while busy would change `dsp_char` on the next edge. A run latch that does not load would show on `run` one cycle after the control write.

// File: rtl/con_io_pkg.sv
package con_io_pkg;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int PAGE_SHIFT = 9;
    localparam logic [DW-PAGE_SHIFT-1:0] DEV_PAGE = '1;

    localparam logic [DW-1:0] A_KSTAT = 16'hFE00;
    localparam logic [DW-1:0] A_KDATA = 16'hFE02;
    localparam logic [DW-1:0] A_DSTAT = 16'hFE04;
    localparam logic [DW-1:0] A_DDATA = 16'hFE06;
    localparam logic [DW-1:0] A_MCTL  = 16'hFFFE;

    localparam int FLAG_BIT = DW - 1;
    localparam int IE_BIT   = DW - 2;

    typedef enum logic {KBD_EMPTY, KBD_FULL} kbd_state_e;
    typedef enum logic {DSP_DONE, DSP_BUSY} dsp_state_e;
endpackage

// File: rtl/con_kbd_port.sv
module con_kbd_port
    import con_io_pkg::*;
#(
    parameter int CHW = CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [CHW-1:0] char_in,
    input  logic           take,
    input  logic           ie_we,
    input  logic           ie_d,
    output logic           ready,
    output logic           ie,
    output logic [CHW-1:0] char_q
);
    kbd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KBD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KBD_EMPTY: if (strobe) state_d = KBD_FULL;
            KBD_FULL:  if (take && !strobe) state_d = KBD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            ie     <= 1'b0;
        end else begin
            if (strobe) char_q <= char_in;
            if (ie_we)  ie     <= ie_d;
        end
    end

    always_comb ready = (state_q == KBD_FULL);

    AST_KBD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (ready && char_q == $past(char_in))); // R3
    AST_KBD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !strobe) |=> !ready); // R3
endmodule

// File: rtl/con_dsp_port.sv
module con_dsp_port
    import con_io_pkg::*;
#(
    parameter int CHW = CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           send,
    input  logic [CHW-1:0] char_in,
    input  logic           ack,
    input  logic           ie_we,
    input  logic           ie_d,
    output logic           done,
    output logic           ie,
    output logic [CHW-1:0] char_q,
    output logic           valid
);
    dsp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DSP_DONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DSP_DONE: if (send) state_d = DSP_BUSY;
            DSP_BUSY: if (ack)  state_d = DSP_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            ie     <= 1'b0;
        end else begin
            if (send && state_q == DSP_DONE) char_q <= char_in;
            if (ie_we) ie <= ie_d;
        end
    end

    always_comb begin
        done  = (state_q == DSP_DONE);
        valid = (state_q == DSP_BUSY);
    end

    AST_DSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (valid && $stable(char_q))); // R5
    AST_DSP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack) |=> (done && !valid)); // R5
    AST_DSP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && send) |=> $stable(char_q)); // R6
endmodule

// File: rtl/con_run_latch.sv
module con_run_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic run
);
    always_ff @(posedge clk) begin
        if (!rst_n)  run <= 1'b1;
        else if (we) run <= d;
    end

    AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !d) |=> !run); // R8
endmodule

// File: rtl/con_io_regs.sv
module con_io_regs
    import con_io_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          dev_hit,
    input  logic          kbd_strobe,
    input  logic [CW-1:0] kbd_char,
    output logic [CW-1:0] dsp_char,
    output logic          dsp_valid,
    input  logic          dsp_ack,
    output logic          kbd_irq,
    output logic          dsp_irq,
    output logic          run
);
    logic rd, wr;
    logic k_ready, k_ie, d_done, d_ie;
    logic [CW-1:0] k_char;
    logic [DW-1:0] rmux;

    always_comb begin
        dev_hit = (bus_addr[DW-1:PAGE_SHIFT] == DEV_PAGE);
        rd      = bus_sel && !bus_we && dev_hit;
        wr      = bus_sel &&  bus_we && dev_hit;
    end

    con_kbd_port #(.CHW(CW)) u_kbd (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (kbd_strobe),
        .char_in(kbd_char),
        .take   (rd && bus_addr == A_KDATA),
        .ie_we  (wr && bus_addr == A_KSTAT),
        .ie_d   (bus_wdata[IE_BIT]),
        .ready  (k_ready),
        .ie     (k_ie),
        .char_q (k_char)
    );

    con_dsp_port #(.CHW(CW)) u_dsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .send   (wr && bus_addr == A_DDATA),
        .char_in(bus_wdata[CW-1:0]),
        .ack    (dsp_ack),
        .ie_we  (wr && bus_addr == A_DSTAT),
        .ie_d   (bus_wdata[IE_BIT]),
        .done   (d_done),
        .ie     (d_ie),
        .char_q (dsp_char),
        .valid  (dsp_valid)
    );

    con_run_latch u_run (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr && bus_addr == A_MCTL),
        .d    (bus_wdata[FLAG_BIT]),
        .run  (run)
    );

    always_comb begin
        rmux = '0;
        unique case (bus_addr)
            A_KSTAT: begin rmux[FLAG_BIT] = k_ready; rmux[IE_BIT] = k_ie; end
            A_KDATA: rmux[CW-1:0] = k_char;
            A_DSTAT: begin rmux[FLAG_BIT] = d_done; rmux[IE_BIT] = d_ie; end
            A_MCTL:  rmux[FLAG_BIT] = run;
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rmux;
        else         bus_rdata <= '0;
    end

    always_comb begin
        kbd_irq = k_ready && k_ie;
        dsp_irq = d_done && d_ie;
    end

    AST_HIT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_hit |-> (bus_addr >= A_KSTAT)); // R1
    AST_NO_KIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kbd_irq) |-> ($past(kbd_strobe) || $past(wr && bus_addr == A_KSTAT))); // R7
    AST_NO_DIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> !dsp_irq); // R7
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/con_io_regs_tb.sv
module con_io_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic dev_hit;
    logic kbd_strobe = 1'b0;
    logic [7:0] kbd_char = '0;
    logic [7:0] dsp_char;
    logic dsp_valid;
    logic dsp_ack = 1'b0;
    logic kbd_irq, dsp_irq, run;

    int checks = 0, errors = 0;
    bit ended = 0;

    typedef struct { logic [15:0] val; string req; } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    con_io_regs u_dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after each read request
    always @(posedge clk) begin
        bit was_rd;
        was_rd = rst_n && bus_sel && !bus_we;
        #1;
        if (was_rd) begin
            exp_t e;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                e = sb.pop_front();
                chk(e.req, bus_rdata, e.val);
            end
        end
    end

    task automatic rd(input logic [15:0] a, input logic [15:0] e, input string req);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        sb.push_back('{e, req});
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_strobe(input logic [15:0] a, input logic [15:0] e, input logic [7:0] c, input string req);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a; kbd_strobe = 1; kbd_char = c;
        sb.push_back('{e, req});
        @(negedge clk);
        bus_sel = 0; kbd_strobe = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic kstrobe(input logic [7:0] c);
        @(negedge clk);
        kbd_strobe = 1; kbd_char = c;
        @(negedge clk);
        kbd_strobe = 0;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R8 run after reset", {15'b0, run}, 16'h1);
        chk("R7 irqs after reset", {14'b0, kbd_irq, dsp_irq}, 16'h0);
        chk("R5 dsp_valid after reset", {15'b0, dsp_valid}, 16'h0);
        rd(16'hFE00, 16'h0000, "R2 kbd status reset");
        rd(16'hFE04, 16'h8000, "R4 dsp status reset");
        rd(16'hFFFE, 16'h8000, "R8 ctl reset");
        rd(16'hFE08, 16'h0000, "R9 unused in page");
        rd(16'h1234, 16'h0000, "R9 outside page");
        // R1 decode boundaries
        bus_addr = 16'hFE00; #1 chk("R1 FE00", {15'b0, dev_hit}, 16'h1);
        bus_addr = 16'hFDFF; #1 chk("R1 FDFF", {15'b0, dev_hit}, 16'h0);
        bus_addr = 16'hFFFF; #1 chk("R1 FFFF", {15'b0, dev_hit}, 16'h1);
        // keyboard
        kstrobe(8'h41);
        rd(16'hFE00, 16'h8000, "R3 ready after strobe");
        chk("R7 kbd irq disabled", {15'b0, kbd_irq}, 16'h0);
        wr(16'hFE00, 16'hFFFF);
        rd(16'hFE00, 16'hC000, "R2 enable write");
        chk("R7 kbd irq", {15'b0, kbd_irq}, 16'h1);
        rd(16'hFE02, 16'h0041, "R3 data read");
        rd(16'hFE00, 16'h4000, "R3 ready cleared");
        chk("R7 kbd irq after take", {15'b0, kbd_irq}, 16'h0);
        wr(16'hFE00, 16'h8000);
        rd(16'hFE00, 16'h0000, "R2 bit15 not writable");
        kstrobe(8'h42);
        rd_strobe(16'hFE02, 16'h0042, 8'h43, "R3 read with strobe");
        rd(16'hFE00, 16'h8000, "R3 strobe wins");
        rd(16'hFE02, 16'h0043, "R3 new char");
        // display
        wr(16'hFE04, 16'h4000);
        chk("R7 dsp irq", {15'b0, dsp_irq}, 16'h1);
        wr(16'hFE06, 16'h125A);
        chk("R5 valid", {15'b0, dsp_valid}, 16'h1);
        chk("R5 char", {8'h0, dsp_char}, 16'h005A);
        chk("R7 dsp irq busy", {15'b0, dsp_irq}, 16'h0);
        rd(16'hFE04, 16'h4000, "R5 done cleared");
        wr(16'hFE06, 16'h0033);
        chk("R6 char kept", {8'h0, dsp_char}, 16'h005A);
        chk("R5 valid held", {15'b0, dsp_valid}, 16'h1);
        @(negedge clk); dsp_ack = 1;
        @(negedge clk); dsp_ack = 0;
        chk("R5 valid after ack", {15'b0, dsp_valid}, 16'h0);
        rd(16'hFE04, 16'hC000, "R5 done after ack");
        // run latch
        wr(16'hFFFE, 16'h0000);
        chk("R8 run cleared", {15'b0, run}, 16'h0);
        rd(16'hFFFE, 16'h0000, "R8 ctl read");
        wr(16'hFFFE, 16'h8000);
        chk("R8 run set", {15'b0, run}, 16'h1);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule